// File: doc/BRIEF.md
# Dot-Matrix Panel Refresh Sequencer with Vertical Scroll

This block produces the row-by-row refresh of a 64-line by 128-column dot-matrix panel driven at 1/64 duty. It runs from the panel oscillator clock. It divides that clock into a line clock and, during each line period, reads the next pixel row out of a byte-organised display RAM. Each RAM byte holds eight vertically adjacent pixels of one column. The block therefore collects one bit from each of 128 column bytes to build a row. At the chosen edge of the line clock, it moves the completed row into the segment latches and advances a one-hot common select.

A 6-bit start-line value gives hardware vertical scrolling. The block samples it one line ahead of the first common of every frame and uses it to preset the row counter. The row counter then steps by one per line and wraps after 63. The block also provides four controls: a display-enable that blanks the segments, a polarity bit that flips at each frame start, a common scan direction and a segment column order. The pixel level and the polarity bit stand in for the analogue drive levels.

Top module: `lcd_scan_timer`

## Requirements
- R1: During reset and until the first frame begins, all common outputs, all segment outputs and the polarity bit are 0. The first common turns on exactly 2 line periods after reset is released, with the rising-edge phase selected.
- R2: A line period lasts BASE_DIV clocks (default 272) when `fast_osc_i` is 0, and 2*BASE_DIV clocks when it is 1. `line_clk_o` is high for the first half of each period.
- R3: At the line event that precedes the first common of a frame, the row counter is loaded from `start_line_i`. After that it adds 1 per line, modulo 64. A change of `start_line_i` in the middle of a frame only shows from the next frame on.
- R4: Pixel row r is read as bit r mod 8 of the byte at page r/8 and column c. `ram_addr_o` = {page[2:0], column[6:0]}, with the page in the upper 3 bits. Read data is taken one clock after the address. The whole 128-bit row is complete before it is latched, and it is held for one line.
- R5: With `com_dir_i` = 1, frame position p drives `com_o[p]`, so the scan runs from bit 0 upward. With `com_dir_i` = 0 it drives `com_o[63-p]`. Exactly one common is high while scanning.
- R6: `ac_pol_o` inverts at every frame start and does not change at any other time. It is 1 during the first frame.
- R7: With `disp_on_i` = 0, every segment output is 0 while scanning, polarity and row fetching continue. When the display is turned back on in the middle of a line, the current line's pixels reappear at once.
- R8: With `col_asc_i` = 1, `seg_o[s]` shows RAM column s. With it 0, `seg_o[s]` shows column 63-s for s<64 and column 191-s for s≥64, which reverses each half.
- R9: With `shift_edge_i` = 1, rows and commons advance on the clock where `line_clk_o` rises. With it 0, they advance where it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_line_i | input | 6 | RAM row shown on the first common |
| disp_on_i | input | 1 | 1 shows pixels, 0 blanks segments |
| com_dir_i | input | 1 | Common scan direction |
| shift_edge_i | input | 1 | 1 advances on line clock rise, 0 on fall |
| col_asc_i | input | 1 | Segment column order |
| fast_osc_i | input | 1 | 1 doubles the line divider for the faster oscillator |
| ram_data_i | input | 8 | Column byte returned by the display RAM |
| ram_addr_o | output | 10 | {page, column} read address |
| ram_rd_o | output | 1 | Read strobe during row fetch |
| line_clk_o | output | 1 | Divided line clock |
| ac_pol_o | output | 1 | Frame polarity bit |
| com_o | output | 64 | One-hot common select |
| seg_o | output | 128 | Segment pixel levels |

## Verification
The RAM model returns a byte that is a hash of page and column. Every bit of every row therefore differs, so a wrong page, a wrong bit-in-byte or a one-line slip shows up as a segment mismatch. Whole frames are compared line by line. One frame starts at line 0 and one is scrolled to 5, which exposes the wrap from row 63 to row 0 and shows whether a mid-frame start change leaks early. Reversing the commons, mirroring the columns and blanking are each applied in the middle of a line, to separate combinational remapping from latched state. Switching the phase and the divider then pins the row event to the chosen line-clock edge and the chosen period.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
    localparam int unsigned SCAN_ROWS = 64;
    localparam int unsigned SCAN_COLS = 128;
    localparam int unsigned PAGE_BITS = 8;
    localparam int unsigned LINE_BASE = 272;
endpackage

// File: rtl/scan_line_div.sv
module scan_line_div #(
    parameter int unsigned BASE_DIV = lcd_scan_pkg::LINE_BASE
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fast_i,
    input  logic edge_sel_i,
    output logic line_clk_o,
    output logic shift_o
);
    localparam int unsigned CW = $clog2(2 * BASE_DIV + 1);
    localparam logic [CW-1:0] PER_SLOW = CW'(BASE_DIV);
    localparam logic [CW-1:0] PER_FAST = CW'(2 * BASE_DIV);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t q, d;
    logic [CW-1:0] period;
    logic [CW-1:0] half;
    logic          wrap;

    always_comb begin
        period     = fast_i ? PER_FAST : PER_SLOW;
        half       = period >> 1;
        wrap       = (q.cnt >= period - 1'b1);
        d          = q;
        d.cnt      = wrap ? '0 : q.cnt + 1'b1;
        shift_o    = edge_sel_i ? wrap : (q.cnt == half - 1'b1);
        line_clk_o = (q.cnt < half);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    // The counter never leaves the longest line period
    assert_div_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.cnt < PER_FAST);

    // A row event in rising phase is followed by a high line clock
    assert_rise_align_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_o && edge_sel_i) |=> line_clk_o);

    // A row event in falling phase is followed by a low line clock
    assert_fall_align_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_o && !edge_sel_i) |=> (!line_clk_o || (fast_i != $past(fast_i))));
endmodule

// File: rtl/scan_row_fetch.sv
module scan_row_fetch #(
    parameter int unsigned ROWS      = lcd_scan_pkg::SCAN_ROWS,
    parameter int unsigned COLS      = lcd_scan_pkg::SCAN_COLS,
    parameter int unsigned PAGE_BITS = lcd_scan_pkg::PAGE_BITS
) (
    input  logic                                   clk_i,
    input  logic                                   rst_ni,
    input  logic                                   start_i,
    input  logic [$clog2(ROWS)-1:0]                row_i,
    input  logic [PAGE_BITS-1:0]                   ram_data_i,
    output logic [$clog2(ROWS)-$clog2(PAGE_BITS)+$clog2(COLS)-1:0] ram_addr_o,
    output logic                                   ram_rd_o,
    output logic [COLS-1:0]                        row_bits_o
);
    localparam int unsigned RW  = $clog2(ROWS);
    localparam int unsigned BW  = $clog2(PAGE_BITS);
    localparam int unsigned CLW = $clog2(COLS);
    localparam logic [CLW-1:0] LAST_COL = CLW'(COLS - 1);

    typedef struct packed {
        logic            busy;
        logic [CLW-1:0]  col;
        logic            cap_v;
        logic [CLW-1:0]  cap_col;
        logic [COLS-1:0] bits;
    } fetch_t;

    fetch_t q, d;

    always_comb begin
        d         = q;
        d.cap_v   = q.busy;
        d.cap_col = q.col;
        if (start_i) begin
            d.busy = 1'b1;
            d.col  = '0;
        end else if (q.busy) begin
            d.col = q.col + 1'b1;
            if (q.col == LAST_COL) d.busy = 1'b0;
        end
        if (q.cap_v) d.bits[q.cap_col] = ram_data_i[row_i[BW-1:0]];
    end

    assign ram_addr_o = {row_i[RW-1:BW], q.col};
    assign ram_rd_o   = q.busy;
    assign row_bits_o = q.bits;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    // Every column of a row is captured before the row is latched
    assert_fetch_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> (!q.busy && !q.cap_v));
endmodule

// File: rtl/scan_seg_map.sv
module scan_seg_map #(
    parameter int unsigned COLS = lcd_scan_pkg::SCAN_COLS
) (
    input  logic [COLS-1:0] bits_i,
    input  logic            asc_i,
    input  logic            on_i,
    output logic [COLS-1:0] px_o
);
    localparam int unsigned HALF = COLS / 2;

    for (genvar s = 0; s < COLS; s++) begin : g_seg
        localparam int unsigned MIR = (s / HALF) * HALF + (HALF - 1) - (s % HALF);
        assign px_o[s] = on_i & (asc_i ? bits_i[s] : bits_i[MIR]);
    end
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
    parameter int unsigned ROWS      = lcd_scan_pkg::SCAN_ROWS,
    parameter int unsigned COLS      = lcd_scan_pkg::SCAN_COLS,
    parameter int unsigned PAGE_BITS = lcd_scan_pkg::PAGE_BITS,
    parameter int unsigned BASE_DIV  = lcd_scan_pkg::LINE_BASE,
    localparam int unsigned RW = $clog2(ROWS),
    localparam int unsigned AW = RW - $clog2(PAGE_BITS) + $clog2(COLS)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [RW-1:0]        start_line_i,
    input  logic                 disp_on_i,
    input  logic                 com_dir_i,
    input  logic                 shift_edge_i,
    input  logic                 col_asc_i,
    input  logic                 fast_osc_i,
    input  logic [PAGE_BITS-1:0] ram_data_i,
    output logic [AW-1:0]        ram_addr_o,
    output logic                 ram_rd_o,
    output logic                 line_clk_o,
    output logic                 ac_pol_o,
    output logic [ROWS-1:0]      com_o,
    output logic [COLS-1:0]      seg_o
);
    localparam logic [RW-1:0] PRE_LAST = RW'(ROWS - 2);
    localparam logic [RW-1:0] LAST     = RW'(ROWS - 1);

    typedef struct packed {
        logic [RW-1:0]   idx;
        logic [RW-1:0]   line;
        logic            ac;
        logic            active;
        logic [COLS-1:0] seg;
    } scan_t;

    scan_t q, d;
    logic            shift;
    logic [COLS-1:0] row_bits;

    scan_line_div #(.BASE_DIV(BASE_DIV)) u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fast_i     (fast_osc_i),
        .edge_sel_i (shift_edge_i),
        .line_clk_o (line_clk_o),
        .shift_o    (shift)
    );

    scan_row_fetch #(.ROWS(ROWS), .COLS(COLS), .PAGE_BITS(PAGE_BITS)) u_fetch (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (shift),
        .row_i      (q.line),
        .ram_data_i (ram_data_i),
        .ram_addr_o (ram_addr_o),
        .ram_rd_o   (ram_rd_o),
        .row_bits_o (row_bits)
    );

    always_comb begin
        d = q;
        if (shift) begin
            d.idx = q.idx + 1'b1;
            d.seg = row_bits;
            // next position is the last line: fetch the first row of the coming frame
            d.line = (q.idx == PRE_LAST) ? start_line_i : q.line + 1'b1;
            if (q.idx == LAST) begin
                d.ac     = ~q.ac;
                d.active = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.idx    <= PRE_LAST;
            q.line   <= LAST;
            q.ac     <= 1'b0;
            q.active <= 1'b0;
            q.seg    <= '0;
        end else begin
            q <= d;
        end
    end

    for (genvar k = 0; k < ROWS; k++) begin : g_com
        localparam logic [RW-1:0] FWD = RW'(k);
        localparam logic [RW-1:0] REV = RW'(ROWS - 1 - k);
        assign com_o[k] = q.active & (q.idx == (com_dir_i ? FWD : REV));
    end

    scan_seg_map #(.COLS(COLS)) u_map (
        .bits_i (q.seg),
        .asc_i  (col_asc_i),
        .on_i   (disp_on_i),
        .px_o   (seg_o)
    );

    assign ac_pol_o = q.ac;

    assert_line_preset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift && q.idx == PRE_LAST) |=> (q.line == $past(start_line_i)));

    assert_line_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift && q.idx != PRE_LAST) |=> (q.line == $past(q.line) + RW'(1)));

    assert_ac_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ac_pol_o) |-> (q.idx == '0 && q.active));

    assert_com_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(com_o));
endmodule

// File: tb/lcd_scan_timer_test.sv
`timescale 1ns/1ps
module lcd_scan_timer_test;
    localparam int BASE = 272;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [5:0]   start_line;
    logic         disp_on, com_dir, shift_edge, col_asc, fast_osc;
    logic [7:0]   ram_data;
    logic [9:0]   ram_addr;
    logic         ram_rd, line_clk, ac_pol;
    logic [63:0]  com;
    logic [127:0] seg;

    int n_checks = 0;
    int n_fail   = 0;
    int pos, frame_start, next_start;
    logic exp_ac;

    always #2.5 clk = ~clk;

    lcd_scan_timer uut (
        .clk_i(clk), .rst_ni(rst_n), .start_line_i(start_line), .disp_on_i(disp_on),
        .com_dir_i(com_dir), .shift_edge_i(shift_edge), .col_asc_i(col_asc),
        .fast_osc_i(fast_osc), .ram_data_i(ram_data), .ram_addr_o(ram_addr),
        .ram_rd_o(ram_rd), .line_clk_o(line_clk), .ac_pol_o(ac_pol),
        .com_o(com), .seg_o(seg)
    );

    function automatic logic [7:0] pat(input logic [9:0] a);
        return (a[7:0] * 8'd29) ^ {a[9:7], a[9:5]} ^ 8'h5A;
    endfunction

    always @(posedge clk) ram_data <= pat(ram_addr);

    function automatic logic [127:0] exp_seg(input int row, input logic asc, input logic on);
        logic [127:0] v;
        logic [7:0] b;
        int c;
        for (int s = 0; s < 128; s++) begin
            c = asc ? s : ((s / 64) * 64 + 63 - (s % 64));
            b = pat({3'(row / 8), 7'(c)});
            v[s] = on & b[row % 8];
        end
        return v;
    endfunction

    function automatic logic [63:0] exp_com(input int p, input logic dir);
        logic [63:0] v = '0;
        v[dir ? p : 63 - p] = 1'b1;
        return v;
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_line(input string req);
        logic [63:0]  ec = exp_com(pos, com_dir);
        logic [127:0] es = exp_seg((frame_start + pos) % 64, col_asc, disp_on);
        check(com == ec, "R5", {req, " common"}, 128'(com), 128'(ec));
        check(seg == es, "R4", {req, " segments"}, seg, es);
        check(ac_pol == exp_ac, "R6", {req, " polarity"}, 128'(ac_pol), 128'(exp_ac));
    endtask

    task automatic next_line(output int gap);
        logic lc_prev = line_clk;
        logic [63:0] cprev;
        gap = 0;
        forever begin
            cprev = com;
            @(negedge clk);
            gap++;
            if (line_clk != lc_prev) begin
                lc_prev = line_clk;
                if (line_clk == shift_edge) break;
            end
            if (gap > 4 * BASE + 10) begin
                check(1'b0, "R2", "line clock stalled", 128'(gap), 128'(BASE));
                break;
            end
        end
        check(com != cprev, "R9", "common moves on the selected edge", 128'(com), 128'(cprev));
        pos = (pos + 1) % 64;
        if (pos == 63) next_start = start_line;
        if (pos == 0) begin
            frame_start = next_start;
            exp_ac = ~exp_ac;
        end
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        check(com == '0, "R1", "common in reset", 128'(com), 128'(0));
        check(seg == '0, "R1", "segments in reset", seg, 128'(0));
        check(ac_pol == 1'b0, "R1", "polarity in reset", 128'(ac_pol), 128'(0));
        rst_n = 1'b1;
    endtask

    task automatic t_first_frame();
        int n = 0;
        int gap;
        while (com == '0 && n < 4 * BASE) begin
            @(negedge clk);
            n++;
            if (n < 2 * BASE)
                check(seg == '0 && ac_pol == 1'b0, "R1", "idle before first frame",
                      128'(ac_pol), 128'(0));
        end
        check(n == 2 * BASE, "R1", "first common delay", 128'(n), 128'(2 * BASE));
        pos = 0; frame_start = 0; next_start = 0; exp_ac = 1'b1;
        check_line("R3 first frame");
        for (int i = 1; i < 64; i++) begin
            next_line(gap);
            check(gap == BASE, "R2", "slow line period", 128'(gap), 128'(BASE));
            check_line("R3 first frame");
            if (pos == 20) start_line = 6'd5;
        end
    endtask

    task automatic t_scroll();
        int gap;
        for (int i = 0; i < 64; i++) begin
            next_line(gap);
            check_line("R3 scrolled frame");
            if (pos == 0)
                check(seg == exp_seg(5, 1'b1, 1'b1), "R3", "scroll start row 5", seg, exp_seg(5, 1'b1, 1'b1));
            if (pos == 59)
                check(seg == exp_seg(0, 1'b1, 1'b1), "R3", "row wrap to 0", seg, exp_seg(0, 1'b1, 1'b1));
        end
    endtask

    task automatic t_dir();
        int gap;
        next_line(gap);
        repeat (5) @(negedge clk);
        com_dir = 1'b0;
        @(negedge clk);
        check(com == exp_com(pos, 1'b0), "R5", "reversed common mid-line", 128'(com), 128'(exp_com(pos, 1'b0)));
        for (int i = 0; i < 3; i++) begin
            next_line(gap);
            check_line("R5 reversed");
        end
    endtask

    task automatic t_cols();
        int gap;
        col_asc = 1'b0;
        @(negedge clk);
        check(seg == exp_seg((frame_start + pos) % 64, 1'b0, 1'b1), "R8", "mirrored halves", seg,
              exp_seg((frame_start + pos) % 64, 1'b0, 1'b1));
        for (int i = 0; i < 2; i++) begin
            next_line(gap);
            check_line("R8 mirrored");
        end
    endtask

    task automatic t_blank();
        int gap;
        disp_on = 1'b0;
        @(negedge clk);
        check(seg == '0, "R7", "blanked segments", seg, 128'(0));
        next_line(gap);
        check_line("R7 blanked scan continues");
        repeat (20) @(negedge clk);
        disp_on = 1'b1;
        @(negedge clk);
        check(seg == exp_seg((frame_start + pos) % 64, col_asc, 1'b1), "R7", "pixels back mid-line", seg,
              exp_seg((frame_start + pos) % 64, col_asc, 1'b1));
        col_asc = 1'b1;
    endtask

    task automatic t_phase();
        int gap;
        next_line(gap);
        shift_edge = 1'b0;
        next_line(gap);
        check(gap == BASE / 2, "R9", "first falling event", 128'(gap), 128'(BASE / 2));
        check(line_clk == 1'b0, "R9", "line clock low at event", 128'(line_clk), 128'(0));
        check_line("R9 falling phase");
        next_line(gap);
        check(gap == BASE, "R9", "falling phase period", 128'(gap), 128'(BASE));
        check_line("R9 falling phase");
    endtask

    task automatic t_fast();
        int gap;
        fast_osc = 1'b1;
        next_line(gap);
        check_line("R2 fast switch");
        for (int i = 0; i < 2; i++) begin
            next_line(gap);
            check(gap == 2 * BASE, "R2", "fast line period", 128'(gap), 128'(2 * BASE));
            check_line("R2 fast");
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 128'(0), 128'(1));
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_line = 6'd0; disp_on = 1'b1; com_dir = 1'b1;
        shift_edge = 1'b1; col_asc = 1'b1; fast_osc = 1'b0;
        t_reset();
        t_first_frame();
        t_scroll();
        t_dir();
        t_cols();
        t_blank();
        t_phase();
        t_fast();
        summary();
        $finish;
    end
endmodule